// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of granted permissions. It reads page table entries through a one-read-at-a-time memory port, starting from a table base supplied on an input. A request carries the virtual address, the kind of access wanted (read, write or execute) and a mode index (kernel, user or physical). When the translation is finished, the block raises a one-cycle `done` pulse. With that pulse it gives either a success flag with the address and permissions, or a 3-bit fault code.

Some requests finish in the cycle after they are accepted and never touch memory: physical-mode requests, addresses that are not properly sign-extended, and the direct-mapped kernel superpage window. Every other request reads one entry per level at three levels. The final entry decides the access permissions. That entry's fault-on-operation bits can then take permissions away again.

Top module: `pt_walker`

## Requirements
- R1: With `req_mode` = 2 (physical), the result is a success with `res_pa` equal to the virtual address and `res_perm` = 3'b111, and `mem_req` is never raised. `res_perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R2: If virtual address bits 63:43 are not all equal, the walk ends with no memory read and `res_fault` = 1 (access violation).
- R3: An address with bit 63 set and bits 42:41 = 2'b10 is a superpage and causes no memory read. In kernel mode (`req_mode` = 0) the result is a success with permissions 3'b111. The physical address is virtual bits 39:0, with virtual bit 40 placed at physical bit 43. In user mode (`req_mode` = 1) the result is fault 1.
- R4: A walk makes exactly three reads, in order, with `mem_req` high for one cycle per read. The level-1 index is VA[42:33], the level-2 index is VA[32:23] and the level-3 index is VA[22:13]. Each read address is the current base plus 8 times the index, and the first base is `ptbr`.
- R5: The next table base, and the leaf frame, are entry bits 63:32 shifted left by 13. On success, `res_pa` is the leaf frame ORed with VA[12:0].
- R6: At any level, an entry with bit 0 (valid) clear gives fault 2 (translation not valid). At levels 1 and 2, an entry with bit 8 (kernel read enable) clear gives fault 1.
- R7: In the leaf, entry bit 8+mode grants read and execute, and entry bit 12+mode grants write. If the requested access (`req_acc` 0 read, 1 write, 2 execute) is not granted, the result is fault 1.
- R8: After that check, leaf bits 1, 2 and 3 remove read, write and execute respectively. The permissions left over are reported on success.
- R9: If the requested access is granted but then removed by the step in R8, the fault code depends on the access: 3 for read, 4 for write, 5 for execute.
- R10: A `req_valid` that arrives while a walk is in progress is ignored, and the walk in progress completes with its own result.
- R11: `done` is a single-cycle pulse, issued exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation; taken only when idle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access: 0 read, 1 write, 2 execute |
| req_mode | input | 2 | Mode: 0 kernel, 1 user, 2 physical |
| ptbr | input | 64 | Level-1 table base |
| mem_req | output | 1 | Entry read request, one cycle |
| mem_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | Result pulse |
| res_ok | output | 1 | Translation succeeded |
| res_fault | output | 3 | Fault code (0 on success) |
| res_pa | output | 64 | Physical address |
| res_perm | output | 3 | Granted permissions {exec, write, read} |

## Verification
The assertions assume a few things about the inputs:
- `req_acc` never takes the value 3, and `req_mode` never takes the value 3.
- A memory response arrives at least one cycle after its `mem_req`, exactly once for each request.

The stimulus stays within these limits by construction:
- The responder waits one to three cycles before it returns data.
- Only the three defined access codes and the three defined mode codes are ever driven.
- Extra requests are raised during a walk only to show that they are dropped.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_BITS  = 43,
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int KRE_BIT  = 8,
  parameter int KWE_BIT  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_va,
  input  logic [1:0]  req_acc,
  input  logic [1:0]  req_mode,
  input  logic [63:0] ptbr,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        res_ok,
  output logic [2:0]  res_fault,
  output logic [63:0] res_pa,
  output logic [2:0]  res_perm
);
  localparam logic [2:0] F_ACV = 3'd1, F_TNV = 3'd2, F_FOR = 3'd3, F_FOW = 3'd4, F_FOE = 3'd5;
  localparam logic [1:0] M_KERN = 2'd0, M_USER = 2'd1, M_PHYS = 2'd2;
  localparam logic [1:0] LAST = 2'd2;
  localparam logic [63:0] IDX_MASK = (64'd1 << IDX_BITS) - 64'd1;
  localparam logic [63:0] OFF_MASK = (64'd1 << PG_BITS) - 64'd1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;
  logic [1:0]  lvl, acc_q, mode_q;
  logic [63:0] va_q, base_q;

  logic        legal, superpg, fin, f_ok, step;
  logic [2:0]  f_code, f_perm, need, grant, kept;
  logic [63:0] f_pa, frame;
  logic [5:0]  shamt;

  assign legal   = (&req_va[63:VA_BITS]) | ~(|req_va[63:VA_BITS]);
  assign superpg = req_va[63] & (req_va[42:41] == 2'b10);
  assign shamt   = 6'(PG_BITS + IDX_BITS * (LAST - lvl));
  assign mem_req  = (st == S_ISSUE);
  assign mem_addr = base_q + (((va_q >> shamt) & IDX_MASK) << 3);
  assign frame = {mem_rsp_data[63:32], 32'd0} >> (32 - PG_BITS);
  assign need  = 3'b001 << acc_q;
  assign grant = {mem_rsp_data[KRE_BIT + mode_q], mem_rsp_data[KWE_BIT + mode_q],
                  mem_rsp_data[KRE_BIT + mode_q]};
  assign kept  = grant & ~mem_rsp_data[3:1];

  always_comb begin
    fin = 1'b0; f_ok = 1'b0; f_code = 3'd0; f_pa = 64'd0; f_perm = 3'd0; step = 1'b0;
    if (st == S_IDLE && req_valid) begin
      if (req_mode == M_PHYS) begin
        fin = 1'b1; f_ok = 1'b1; f_pa = req_va; f_perm = 3'b111;
      end else if (!legal) begin
        fin = 1'b1; f_code = F_ACV;
      end else if (superpg) begin
        fin = 1'b1;
        if (req_mode == M_KERN) begin
          f_ok = 1'b1; f_perm = 3'b111;
          f_pa = {20'd0, req_va[40], 3'd0, req_va[39:0]};
        end else f_code = F_ACV;
      end
    end else if (st == S_WAIT && mem_rsp_valid) begin
      if (!mem_rsp_data[0]) begin
        fin = 1'b1; f_code = F_TNV;
      end else if (lvl != LAST) begin
        if (!mem_rsp_data[KRE_BIT]) begin fin = 1'b1; f_code = F_ACV; end
        else step = 1'b1;
      end else begin
        fin = 1'b1;
        if ((grant & need) == 3'd0) f_code = F_ACV;
        else if ((kept & need) == 3'd0)
          f_code = need[2] ? F_FOE : (need[1] ? F_FOW : F_FOR);
        else begin
          f_ok = 1'b1; f_perm = kept; f_pa = frame | (va_q & OFF_MASK);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lvl <= 2'd0; acc_q <= 2'd0; mode_q <= 2'd0;
      va_q <= 64'd0; base_q <= 64'd0;
      done <= 1'b0; res_ok <= 1'b0; res_fault <= 3'd0; res_pa <= 64'd0; res_perm <= 3'd0;
    end else begin
      done <= fin;
      if (fin) begin
        res_ok <= f_ok; res_fault <= f_code; res_pa <= f_pa; res_perm <= f_perm;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; acc_q <= req_acc; mode_q <= req_mode;
          base_q <= ptbr; lvl <= 2'd0;
          if (!fin) st <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (fin) st <= S_IDLE;
                else if (step) begin
                  st <= S_ISSUE; lvl <= lvl + 2'd1; base_q <= frame;
                end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
  AST_NO_READ_PHYS: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mode_q != M_PHYS); // R1
  AST_OK_HAS_NEED: assert property (@(posedge clk) disable iff (!rst_n) done && res_ok |-> (res_perm & need) != 3'd0); // R8
  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done && !res_ok |-> res_fault >= F_ACV && res_fault <= F_FOE); // R9
  AST_SUPER_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_ok && mode_q == M_USER |-> !(va_q[63] && va_q[42:41] == 2'b10)); // R3
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_rsp_valid = 0;
  logic [63:0] req_va = 0, ptbr = 64'h0000_0000_0010_0000, mem_rsp_data = 0;
  logic [1:0] req_acc = 0, req_mode = 0;
  logic mem_req, done, res_ok;
  logic [63:0] mem_addr, res_pa;
  logic [2:0] res_fault, res_perm;
  int tests = 0, fails = 0;
  logic [63:0] pmem [logic [63:0]];

  always #5 clk = ~clk;

  pt_walker u0 (.clk, .rst_n, .req_valid, .req_va, .req_acc, .req_mode, .ptbr,
    .mem_req, .mem_addr, .mem_rsp_valid, .mem_rsp_data, .done, .res_ok,
    .res_fault, .res_pa, .res_perm);

  localparam logic [31:0] V = 32'h1, FR = 32'h2, FW = 32'h4, FE = 32'h8,
    KRE = 32'h100, URE = 32'h200, KWE = 32'h1000, UWE = 32'h2000;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  function automatic void model(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
      output logic ok, output logic [2:0] code, output logic [63:0] pa, output logic [2:0] perm,
      output int n, output logic [63:0] addrs [3]);
    logic [63:0] base, pte;
    logic [2:0] g, nd;
    ok = 0; code = 0; pa = 0; perm = 0; n = 0;
    for (int i = 0; i < 3; i++) addrs[i] = 0;
    if (mode == 2) begin ok = 1; pa = va; perm = 7; return; end
    if (($signed(va) >>> 43) != ($signed(va) >>> 63)) begin code = 1; return; end
    if (va[63] && va[42:41] == 2) begin
      if (mode != 0) begin code = 1; return; end
      ok = 1; perm = 7; pa = (va & ((64'd1 << 40) - 1)) | (va[40] ? (64'd1 << 43) : 64'd0);
      return;
    end
    base = ptbr;
    for (int l = 0; l < 3; l++) begin
      addrs[l] = base + ((va >> (13 + 10 * (2 - l))) & 64'd1023) * 8;
      n++;
      pte = rd(addrs[l]);
      if (!pte[0]) begin code = 2; return; end
      if (l < 2) begin
        if (!pte[8]) begin code = 1; return; end
        base = (pte >> 32) << 13;
      end
    end
    g = 0;
    if (pte[8 + mode]) g = g | 3'b101;
    if (pte[12 + mode]) g = g | 3'b010;
    nd = 3'b001 << acc;
    if ((g & nd) == 0) begin code = 1; return; end
    g = g & ~pte[3:1];
    if ((g & nd) == 0) begin code = (acc == 2) ? 5 : (acc == 1) ? 4 : 3; return; end
    ok = 1; perm = g; pa = ((pte >> 32) << 13) | (va & 64'h1FFF);
  endfunction

  task automatic build(logic [63:0] va, logic [31:0] f1, logic [31:0] f2, logic [63:0] leaf,
                       logic [31:0] p2, logic [31:0] p3);
    pmem[ptbr + ((va >> 33) & 1023) * 8] = {p2, f1};
    pmem[({32'd0, p2} << 13) + ((va >> 23) & 1023) * 8] = {p3, f2};
    pmem[({32'd0, p3} << 13) + ((va >> 13) & 1023) * 8] = leaf;
  endtask

  task automatic run(string tag, logic [63:0] va, logic [1:0] acc, logic [1:0] mode,
                     int lat, bit inject);
    logic eok; logic [2:0] ecode, eperm; logic [63:0] epa; int en, k, cyc;
    logic [63:0] ea [3];
    bit seen;
    model(va, acc, mode, eok, ecode, epa, eperm, en, ea);
    @(negedge clk);
    req_valid = 1; req_va = va; req_acc = acc; req_mode = mode;
    @(negedge clk);
    req_valid = 0;
    k = 0; seen = 0; cyc = 0;
    while (!seen && cyc < 60) begin
      cyc++;
      if (done) begin
        seen = 1;
        chk({tag, " ok"}, res_ok, eok);
        if (eok) begin
          chk({tag, " pa"}, res_pa, epa);
          chk({tag, " perm"}, res_perm, eperm);
        end else chk({tag, " fault"}, res_fault, ecode);
        chk({tag, " reads"}, k, en);
      end else if (mem_req) begin
        if (k < 3) chk({tag, " R4 addr"}, mem_addr, ea[k]);
        k++;
        for (int i = 0; i < lat; i++) begin
          if (inject && i == 0) begin
            req_valid = 1; req_mode = 2; req_va = 64'h5A5A;
          end
          @(negedge clk);
          req_valid = 0;
          if (done) chk({tag, " early done"}, done, 0);
        end
        mem_rsp_valid = 1; mem_rsp_data = rd(mem_addr);
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = 0;
      end else @(negedge clk);
    end
    chk({tag, " done seen"}, seen, 1);
    @(negedge clk);
    chk({tag, " R11 pulse"}, done, 0);
  endtask

  initial begin
    logic [63:0] va;
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R1 reset memreq", mem_req, 0);
    rst_n = 1;
    run("R1 phys", 64'hDEAD_BEEF_0123_4567, 0, 2, 1, 0);
    run("R2 high", 64'h0000_1000_0000_0000, 0, 0, 1, 0);
    run("R2 neg", 64'h8000_0000_0000_0000, 0, 1, 1, 0);
    run("R3 kern", 64'hFFFF_FD01_2345_6789, 1, 0, 1, 0);
    run("R3 kern b40clr", 64'hFFFF_FC00_0000_1000, 2, 0, 1, 0);
    run("R3 user", 64'hFFFF_FD01_2345_6789, 0, 1, 1, 0);
    va = 64'h0000_0002_468A_C123;
    build(va, V | KRE, V | KRE, {32'h000A_BCDE, V | KRE | KWE}, 32'h100, 32'h200);
    run("R5 kread", va, 0, 0, 1, 0);
    run("R7 kwrite", va, 1, 0, 2, 0);
    run("R7 uread denied", va, 0, 1, 3, 0);
    va = 64'h0000_0004_0080_4000;
    build(va, V | KRE, V | KRE, {32'h0001_2345, V | URE | UWE}, 32'h110, 32'h210);
    run("R7 user rwx", va, 2, 1, 1, 0);
    run("R7 kern denied", va, 0, 0, 1, 0);
    va = 64'h0000_0006_0100_6000;
    build(va, V | KRE, V | KRE, {32'h0003_0000, V | KRE | FR}, 32'h120, 32'h220);
    run("R9 for", va, 0, 0, 2, 0);
    run("R8 exec kept", va, 2, 0, 1, 0);
    va = 64'h0000_0008_0180_8000;
    build(va, V | KRE, V | KRE, {32'h0004_0000, V | KRE | KWE | FE | FW}, 32'h130, 32'h230);
    run("R9 foe", va, 2, 0, 1, 0);
    run("R9 fow", va, 1, 0, 1, 0);
    run("R8 read only", va, 0, 0, 1, 0);
    va = 64'h0000_000A_0200_A000;
    build(va, 32'h0 | KRE, V | KRE, {32'h5, V | KRE}, 32'h140, 32'h240);
    run("R6 l1 tnv", va, 0, 0, 1, 0);
    va = 64'h0000_000C_0280_C000;
    build(va, V | KRE, V, {32'h5, V | KRE}, 32'h150, 32'h250);
    run("R6 l2 acv", va, 0, 0, 1, 0);
    va = 64'h0000_000E_0300_E000;
    build(va, V | KRE, V | KRE, {32'h5, KRE}, 32'h160, 32'h260);
    run("R6 l3 tnv", va, 0, 0, 2, 0);
    va = 64'h0000_0002_468A_C123;
    run("R10 busy ignore", va, 0, 0, 3, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule